// File: doc/BRIEF.md
# Partitioned SIMD Integer Lane

A 256-bit integer lane for a vector unit. Each operation selects its own element width, so the same datapath works as sixteen 16-bit, eight 32-bit or four 64-bit elements. The lane supports add, subtract, multiply, AND, OR, shift left and shift right. Elements are read as either signed or unsigned integers.

Either operand can be taken from a 64-bit scalar input. The low element-width bits of that scalar are replicated into every element position. When an arithmetic result does not fit, the lane can clamp it to the nearest representable value. It can instead keep the low bits and raise a per-element overflow flag. A per-element mask chooses which elements are written.

Results, flags and write enables appear one clock after a valid request, together with a valid strobe.

Top module: `simd_alu_lane`

## Requirements
- R1: `width_i` selects the element width EW: 0 gives 16 elements of 16 bits, 1 gives 8 of 32, and 2 (or 3) gives 4 of 64. Element i occupies bits [i*EW +: EW] of the operands and of `result_o`, and no carry or shifted bit crosses an element boundary.
- R2: `op_i` encodes the operation: 0 add, 1 subtract (a-b), 2 multiply (low EW bits of the product), 3 AND, 4 OR, 5 shift left, 6 shift right. The shift amount is the low log2(EW) bits of the b element. Shift right is arithmetic when signed and logical when unsigned.
- R3: `form_i` picks the operands: 0 takes a and b from the vectors, 1 replaces b with the broadcast scalar, and 2 replaces a with the broadcast scalar. The broadcast is `scalar_i[EW-1:0]` in every element. Subtract and shifts always compute a op b.
- R4: With `sat_i`=1, an add, subtract or multiply whose exact result is out of range is clamped. Signed results go to -2^(EW-1) or 2^(EW-1)-1. Unsigned results go to 0 or 2^EW-1.
- R5: With `sat_i`=0, the lane keeps the low EW bits and sets `ovf_o[i]` when the exact add, subtract or multiply result is out of range. Logic operations and shifts never flag. `ovf_o` is all zero in saturating mode.
- R6: With `masked_i`=1, `wen_o[i]` equals `mask_i[i]` for each element i. With `masked_i`=0, all element enables are set. Enable and flag bits at or above the element count are zero, and `ovf_o[i]` is set only where `wen_o[i]` is set.
- R7: `signed_i` selects two's-complement interpretation of the elements. This affects the overflow range, the clamp values and shift right.
- R8: Outputs are registered. `valid_o` equals `valid_i` from the previous cycle. When `valid_o` is low, `wen_o` and `ovf_o` are zero.
- R9: While `rst_ni` is low, `valid_o`, `result_o`, `wen_o` and `ovf_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| width_i | input | 2 | Element width select |
| signed_i | input | 1 | Signed element interpretation |
| sat_i | input | 1 | Saturate instead of wrap |
| form_i | input | 2 | Operand form |
| masked_i | input | 1 | Apply element mask |
| vec_a_i | input | 256 | First vector operand |
| vec_b_i | input | 256 | Second vector operand |
| scalar_i | input | 64 | Scalar for broadcast |
| mask_i | input | 16 | Per-element write mask |
| valid_o | output | 1 | Result strobe |
| result_o | output | 256 | Element results |
| ovf_o | output | 16 | Per-element overflow flags |
| wen_o | output | 16 | Per-element write enables |

## Verification
A carry or shift bit that leaks across an element boundary corrupts the neighbouring element. A wrong range test either flips an `ovf_o` bit or replaces a wrapped value with a clamp. A bad width select shows up in the element count of `wen_o`. Each of these becomes visible on the cycle after the request, because there is only one register stage. The bench therefore sweeps every width, operation, signedness, saturation mode and operand form, using boundary element values that sit right at the range limits.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6
  } simd_op_e;

  typedef enum logic [1:0] {
    FORM_VV = 2'd0,
    FORM_VS = 2'd1,
    FORM_SV = 2'd2
  } simd_form_e;
endpackage

// File: rtl/simd_opnd.sv
module simd_opnd import simd_pkg::*; #(
  parameter int DW = 256,
  parameter int EW = 16,
  localparam int NE = DW / EW
) (
  input  logic [DW-1:0] vec_a_i,
  input  logic [DW-1:0] vec_b_i,
  input  logic [EW-1:0] scalar_i,
  input  logic [1:0]    form_i,
  output logic [DW-1:0] opa_o,
  output logic [DW-1:0] opb_o
);
  logic [DW-1:0] bcast;
  assign bcast = {NE{scalar_i}};

  always_comb begin
    opa_o = vec_a_i;
    opb_o = vec_b_i;
    case (form_i)
      FORM_VS: opb_o = bcast;
      FORM_SV: opa_o = bcast;
      default: ;
    endcase
  end
endmodule

// File: rtl/simd_elem.sv
module simd_elem import simd_pkg::*; #(
  parameter int EW = 16,
  localparam int SW = $clog2(EW),
  localparam int PW = 2 * EW
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  simd_op_e      op_i,
  input  logic          sgn_i,
  input  logic          sat_i,
  output logic [EW-1:0] res_o,
  output logic          ovf_o
);
  logic [EW:0]   ax, bx, sum, dif;
  logic [PW-1:0] pa, pb, prod;
  logic [EW-1:0] smax, smin, wrap, clamp;
  logic [SW-1:0] sh;
  logic          ov;

  always_comb begin
    ax   = {sgn_i & a_i[EW-1], a_i};
    bx   = {sgn_i & b_i[EW-1], b_i};
    sum  = ax + bx;
    dif  = ax - bx;
    pa   = sgn_i ? {{EW{a_i[EW-1]}}, a_i} : {{EW{1'b0}}, a_i};
    pb   = sgn_i ? {{EW{b_i[EW-1]}}, b_i} : {{EW{1'b0}}, b_i};
    prod = pa * pb;
    sh   = b_i[SW-1:0];
    smax = {1'b0, {(EW-1){1'b1}}};
    smin = {1'b1, {(EW-1){1'b0}}};
    ov    = 1'b0;
    clamp = '0;
    wrap  = '0;
    case (op_i)
      OP_ADD: begin
        wrap  = sum[EW-1:0];
        ov    = sgn_i ? (sum[EW] ^ sum[EW-1]) : sum[EW];
        clamp = sgn_i ? (sum[EW] ? smin : smax) : '1;
      end
      OP_SUB: begin
        wrap  = dif[EW-1:0];
        ov    = sgn_i ? (dif[EW] ^ dif[EW-1]) : dif[EW];
        clamp = sgn_i ? (dif[EW] ? smin : smax) : '0;
      end
      OP_MUL: begin
        wrap  = prod[EW-1:0];
        ov    = sgn_i ? (prod[PW-1:EW-1] != {(EW+1){prod[EW-1]}}) : (|prod[PW-1:EW]);
        clamp = sgn_i ? (prod[PW-1] ? smin : smax) : '1;
      end
      OP_AND: wrap = a_i & b_i;
      OP_OR:  wrap = a_i | b_i;
      OP_SHL: wrap = a_i << sh;
      OP_SHR: wrap = sgn_i ? EW'($signed(a_i) >>> sh) : (a_i >> sh);
      default: ;
    endcase
    res_o = (ov && sat_i) ? clamp : wrap;
    ovf_o = ov && !sat_i;
  end

  // unsigned clamping never moves a result past its first operand
  always_comb begin
    if (sat_i && !sgn_i && op_i == OP_ADD)
      assert_usat_add_floor_R4: assert (res_o >= a_i);
    if (sat_i && !sgn_i && op_i == OP_SUB)
      assert_usat_sub_ceiling_R4: assert (res_o <= a_i);
  end
endmodule

// File: rtl/simd_alu_lane.sv
module simd_alu_lane import simd_pkg::*; #(
  parameter int DW     = 256,
  parameter int MIN_EW = 16,
  localparam int NW    = 3,
  localparam int SCW   = MIN_EW << (NW - 1),
  localparam int MAXE  = DW / MIN_EW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [1:0]      width_i,
  input  logic            signed_i,
  input  logic            sat_i,
  input  logic [1:0]      form_i,
  input  logic            masked_i,
  input  logic [DW-1:0]   vec_a_i,
  input  logic [DW-1:0]   vec_b_i,
  input  logic [SCW-1:0]  scalar_i,
  input  logic [MAXE-1:0] mask_i,
  output logic            valid_o,
  output logic [DW-1:0]   result_o,
  output logic [MAXE-1:0] ovf_o,
  output logic [MAXE-1:0] wen_o
);
  simd_op_e op_e;
  assign op_e = simd_op_e'(op_i);

  logic [NW-1:0][DW-1:0]   res_w;
  logic [NW-1:0][MAXE-1:0] ovf_w;

  for (genvar g = 0; g < NW; g++) begin : g_width
    localparam int EW = MIN_EW << g;
    localparam int NE = DW / EW;
    logic [DW-1:0] opa, opb;

    simd_opnd #(.DW(DW), .EW(EW)) i_opnd (
      .vec_a_i  (vec_a_i),
      .vec_b_i  (vec_b_i),
      .scalar_i (scalar_i[EW-1:0]),
      .form_i   (form_i),
      .opa_o    (opa),
      .opb_o    (opb)
    );

    for (genvar e = 0; e < NE; e++) begin : g_elem
      simd_elem #(.EW(EW)) i_elem (
        .a_i   (opa[e*EW +: EW]),
        .b_i   (opb[e*EW +: EW]),
        .op_i  (op_e),
        .sgn_i (signed_i),
        .sat_i (sat_i),
        .res_o (res_w[g][e*EW +: EW]),
        .ovf_o (ovf_w[g][e])
      );
    end

    if (NE < MAXE) begin : g_pad
      assign ovf_w[g][MAXE-1:NE] = '0;
    end
  end

  logic [1:0]      wsel;
  logic [MAXE-1:0] en;

  always_comb begin
    wsel = (width_i == 2'd0) ? 2'd0 : (width_i == 2'd1) ? 2'd1 : 2'd2;
    for (int i = 0; i < MAXE; i++)
      en[i] = (i < (MAXE >> wsel)) && (!masked_i || mask_i[i]);
  end

  logic            valid_q;
  logic [DW-1:0]   res_q;
  logic [MAXE-1:0] ovf_q, wen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      ovf_q   <= '0;
      wen_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q <= res_w[wsel];
        ovf_q <= ovf_w[wsel] & en;
        wen_q <= en;
      end
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign ovf_o    = valid_q ? ovf_q : '0;
  assign wen_o    = valid_q ? wen_q : '0;

  assert_valid_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && wen_o == '0 && ovf_o == '0));
  assert_unmasked_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !masked_i) |=> ($countones(wen_o) == (MAXE >> $past(wsel))));
  assert_masked_subset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && masked_i) |=> ((wen_o & ~$past(mask_i)) == '0));
  assert_no_flag_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sat_i) |=> (ovf_o == '0));
endmodule

// File: tb/test_simd_alu_lane.sv
`timescale 1ns/1ps
module test_simd_alu_lane;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [2:0]   op = '0;
  logic [1:0]   width = '0;
  logic         sgn = 1'b0;
  logic         sat = 1'b0;
  logic [1:0]   form = '0;
  logic         masked = 1'b0;
  logic [255:0] va = '0, vb = '0;
  logic [63:0]  scal = '0;
  logic [15:0]  mask = '0;
  logic         valid_o;
  logic [255:0] result_o;
  logic [15:0]  ovf_o, wen_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [63:0] rnd = 64'h9e3779b97f4a7c15;

  always #4 clk = ~clk;

  simd_alu_lane i_simd_alu_lane (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .width_i(width),
    .signed_i(sgn), .sat_i(sat), .form_i(form), .masked_i(masked),
    .vec_a_i(va), .vec_b_i(vb), .scalar_i(scal), .mask_i(mask),
    .valid_o(valid_o), .result_o(result_o), .ovf_o(ovf_o), .wen_o(wen_o)
  );

  task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rnd();
    rnd = rnd ^ (rnd << 13);
    rnd = rnd ^ (rnd >> 7);
    rnd = rnd ^ (rnd << 17);
    return rnd;
  endfunction

  function automatic logic [63:0] emask(input int ew);
    return (ew == 64) ? 64'hffff_ffff_ffff_ffff : ((64'd1 << ew) - 64'd1);
  endfunction

  // boundary-biased element value
  function automatic logic [63:0] pick(input int ew);
    logic [63:0] m = emask(ew);
    logic [63:0] r = next_rnd();
    case (r[63:61])
      3'd0: return 64'd0;
      3'd1: return 64'd1;
      3'd2: return m >> 1;
      3'd3: return (m >> 1) + 64'd1;
      3'd4: return m;
      default: return next_rnd() & m;
    endcase
  endfunction

  // exact-arithmetic reference
  task automatic model(input int o, input int ew, input bit s, input bit st,
                       input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] r, output bit ovf);
    logic [63:0] m = emask(ew);
    logic signed [131:0] xa, xb, x, lo, hi;
    int sh;
    xa = $signed({68'd0, a & m});
    xb = $signed({68'd0, b & m});
    if (s && a[ew-1]) xa = xa - (132'sd1 <<< ew);
    if (s && b[ew-1]) xb = xb - (132'sd1 <<< ew);
    lo = s ? -(132'sd1 <<< (ew-1)) : 132'sd0;
    hi = s ? ((132'sd1 <<< (ew-1)) - 132'sd1) : ((132'sd1 <<< ew) - 132'sd1);
    sh = int'(b & 64'(ew - 1));
    ovf = 1'b0;
    r = '0;
    case (o)
      0, 1, 2: begin
        x = (o == 0) ? xa + xb : (o == 1) ? xa - xb : xa * xb;
        if (x < lo || x > hi) begin
          if (st) begin
            x = (x < lo) ? lo : hi;
          end else begin
            ovf = 1'b1;
          end
        end
        r = x[63:0] & m;
      end
      3: r = a & b & m;
      4: r = (a | b) & m;
      5: r = (a << sh) & m;
      default: begin
        if (s) begin
          x = xa >>> sh;
          r = x[63:0] & m;
        end else begin
          r = (a & m) >> sh;
        end
      end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] er;
    logic [15:0]  ew_exp, eo_exp;
    logic [63:0]  ea, eb, r;
    bit           ov;
    int           ew, ne;
    string        tag;

    repeat (3) @(negedge clk);
    chk("R9", "valid in reset", 256'(valid_o), 256'd0);
    chk("R9", "result in reset", result_o, 256'd0);
    chk("R9", "wen in reset", 256'(wen_o), 256'd0);
    chk("R9", "ovf in reset", 256'(ovf_o), 256'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int w = 0; w < 3; w++) begin
      for (int o = 0; o < 7; o++) begin
        for (int s = 0; s < 2; s++) begin
          for (int st = 0; st < 2; st++) begin
            for (int fm = 0; fm < 3; fm++) begin
              for (int p = 0; p < 3; p++) begin
                ew = 16 << w;
                ne = 256 / ew;
                va = '0;
                vb = '0;
                for (int i = 0; i < ne; i++) begin
                  va = va | (256'(pick(ew)) << (i * ew));
                  vb = vb | (256'(pick(ew)) << (i * ew));
                end
                scal = (p == 1) ? pick(ew) | (next_rnd() & ~emask(ew)) : next_rnd();
                mask = next_rnd()[15:0];
                masked = (p == 2);
                op = 3'(o);
                width = 2'(w);
                sgn = s[0];
                sat = st[0];
                form = 2'(fm);
                valid = 1'b1;

                er = '0;
                ew_exp = '0;
                eo_exp = '0;
                for (int i = 0; i < ne; i++) begin
                  ea = (fm == 2) ? scal : 64'(va >> (i * ew));
                  eb = (fm == 1) ? scal : 64'(vb >> (i * ew));
                  model(o, ew, s[0], st[0], ea, eb, r, ov);
                  er = er | (256'(r) << (i * ew));
                  ew_exp[i] = !masked || mask[i];
                  eo_exp[i] = ov && ew_exp[i];
                end

                @(negedge clk);
                if (o >= 5)               tag = "R2";
                else if (o <= 2 && st == 1) tag = "R4";
                else if (fm != 0)         tag = "R3";
                else if (s == 1)          tag = "R7";
                else                      tag = "R1";
                chk(tag, $sformatf("result w%0d op%0d s%0d sat%0d f%0d", w, o, s, st, fm), result_o, er);
                chk("R5", "overflow flags", 256'(ovf_o), 256'(eo_exp));
                chk("R6", "write enables", 256'(wen_o), 256'(ew_exp));
                chk("R8", "valid after request", 256'(valid_o), 256'd1);
                valid = 1'b0;
                @(negedge clk);
                chk("R8", "idle outputs", 256'({valid_o, wen_o, ovf_o}), 256'd0);
              end
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule